// File: doc/BRIEF.md
# 8-bit Accumulator Processor Core

A small multi-cycle processor built around a single 8-bit accumulator. Every instruction is one byte, or two bytes when it carries an immediate or a branch target. Code sits in a 256-byte read-only image that is fixed at elaboration through a parameter. Data sits in a 256-byte RAM, and its lowest sixteen bytes serve as the working registers r0 to r15. A controller steps through fetch, execute and a few extra states for indirect accesses. Memory reads take one cycle. A 9-bit read address chooses between the code image (top bit 0) and the data RAM (top bit 1).

The core sees the outside world through one byte-wide input and one byte-wide output. Both are plain level pins and have no handshake. The input is sampled only on the clock edge that completes an I/O instruction. The output holds its value until the next I/O instruction. Nothing is streamed, so there is no back-pressure. The accumulator and a halted flag are brought out so that a test environment can observe progress. After the exit byte the core parks and never fetches again until reset.

Top module: `acc8_core`

## Requirements
- R1: While `rst_n` is low and right after it rises, `acc`, `io_out` and `halted` are 0. Execution starts at address 0 with the carry flag cleared.
- R2: A register ALU byte `0fff rrrr` sets A to f(A, m[r]) in 2 cycles. The function codes are 000 add, 001 sub, 010 add-with-carry, 011 subtract-with-borrow, 100 and, 101 or, 110 xor and 111 load.
- R3: An immediate ALU instruction `1100 xfff` followed by byte n sets A to f(A, n) with the same codes in 2 cycles. Execution then continues after the immediate byte.
- R4: Add and add-with-carry set carry to the bit-8 carry out. Sub and subtract-with-borrow set carry to 1 when no borrow occurs. Add-with-carry adds the old carry, and subtract-with-borrow subtracts the inverse of the old carry. Logic operations and load leave carry unchanged.
- R5: `1000 rrrr` writes A into m[r] in 2 cycles. A and carry are unchanged.
- R6: `1001 rrrr` writes the address of the following byte into m[r] and continues at address A, in 2 cycles.
- R7: `1010 rrrr` sets A to m[m[r]] and takes 4 cycles.
- R8: `1011 rrrr` writes A into m[m[r]] and takes 3 cycles.
- R9: `1101 xxcc` followed by byte t jumps to t when cc is 00 (always), when cc is 10 and A is zero, or when cc is 11 and A is nonzero. Code 01 never jumps. A branch that is not taken continues after byte t. It takes 2 cycles.
- R10: `1110 xxss` shifts A in 2 cycles. ss=00 shifts left logically, 01 shifts right logically, 10 rotates left through carry and 11 rotates right through carry. In every case the bit shifted out goes to carry.
- R11: `1111 aaaa` with aaaa not 1111 copies A to `io_out` and loads A from `io_in` on the same edge, in 2 cycles. No other instruction changes `io_out`.
- R12: Byte 0xFF raises `halted` one cycle after its fetch. From then on `acc`, `io_out` and the program counter never change, whatever `io_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_in | input | 8 | Byte read by the I/O instruction |
| io_out | output | 8 | Byte written by the I/O instruction |
| acc | output | 8 | Current accumulator value |
| halted | output | 1 | High once the exit byte has been executed |

## Verification
The test program uses the carry chain across instruction boundaries. An adc follows an add that overflowed, and an sbb follows a sub that borrowed. A core with the wrong borrow polarity, or one that lets logic operations clear carry, therefore drifts away from the reference accumulator within a few cycles. The rotates run with carry set, so a plain shift that drops the carry-in shows up at once.

Branches are exercised taken and not taken, including the never-taken code 01. A core that forgets to skip the target byte on a fall-through would execute that byte as an opcode. A subroutine call and return check that the link value is the address after the call and not the call itself. An indirect store is followed by an indirect load through the same pointer, which exposes a swapped pointer or data stage. The per-cycle comparison of the accumulator also catches any instruction that takes a cycle too many or too few.

After halt, `io_in` keeps toggling. A core that still reacts to it would change `acc` or `io_out`.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int DW        = 8;
  localparam int AW        = 8;
  localparam int RA_W      = AW + 1;
  localparam int ROM_BYTES = 1 << AW;
  localparam int RIDX      = 4;

  typedef enum logic [2:0] {
    S_FETCH, S_EXEC, S_STI, S_LDI1, S_LDI2, S_EXIT
  } state_e;

  typedef enum logic [2:0] {
    F_ADD, F_SUB, F_ADC, F_SBB, F_AND, F_OR, F_XOR, F_LD
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_SLL, SH_SRL, SH_RLC, SH_RRC
  } sh_fn_e;

  localparam logic [3:0] OP_ST   = 4'h8;
  localparam logic [3:0] OP_BRL  = 4'h9;
  localparam logic [3:0] OP_LDI  = 4'hA;
  localparam logic [3:0] OP_STI  = 4'hB;
  localparam logic [3:0] OP_ALUI = 4'hC;
  localparam logic [3:0] OP_BR   = 4'hD;
  localparam logic [3:0] OP_SH   = 4'hE;
  localparam logic [3:0] OP_IO   = 4'hF;

  localparam logic [DW-1:0] EXIT_CODE = '1;
endpackage

// File: rtl/acc8_alu.sv
module acc8_alu import acc8_pkg::*; #(
  parameter int W = DW
) (
  input  logic [2:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout,
  output logic         cwe
);
  logic [W:0] sum;
  logic [W:0] cext;
  logic [W:0] bext;

  assign cext = {{W{1'b0}}, cin};
  assign bext = {1'b0, b};

  always_comb begin
    sum  = '0;
    y    = a;
    cout = cin;
    cwe  = 1'b0;
    case (alu_fn_e'(fn))
      F_ADD: begin
        sum = {1'b0, a} + bext;
        y = sum[W-1:0]; cout = sum[W]; cwe = 1'b1;
      end
      F_SUB: begin
        sum = {1'b0, a} - bext;
        y = sum[W-1:0]; cout = ~sum[W]; cwe = 1'b1;
      end
      F_ADC: begin
        sum = {1'b0, a} + bext + cext;
        y = sum[W-1:0]; cout = sum[W]; cwe = 1'b1;
      end
      F_SBB: begin
        sum = {1'b0, a} - bext - ({(W+1){1'b0}} | {{W{1'b0}}, ~cin});
        y = sum[W-1:0]; cout = ~sum[W]; cwe = 1'b1;
      end
      F_AND:   y = a & b;
      F_OR:    y = a | b;
      F_XOR:   y = a ^ b;
      F_LD:    y = b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/acc8_shift.sv
module acc8_shift import acc8_pkg::*; #(
  parameter int W = DW
) (
  input  logic [1:0]   fn,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);
  always_comb begin
    case (sh_fn_e'(fn))
      SH_SLL:  begin y = {a[W-2:0], 1'b0}; cout = a[W-1]; end
      SH_SRL:  begin y = {1'b0, a[W-1:1]}; cout = a[0];   end
      SH_RLC:  begin y = {a[W-2:0], cin};  cout = a[W-1]; end
      SH_RRC:  begin y = {cin, a[W-1:1]};  cout = a[0];   end
      default: begin y = a; cout = cin; end
    endcase
  end
endmodule

// File: rtl/acc8_mem.sv
module acc8_mem import acc8_pkg::*; #(
  parameter logic [DW*ROM_BYTES-1:0] PROG = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] rd_addr,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [DW-1:0]   wd,
  output logic [DW-1:0]   rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]   ram [DEPTH];
  logic [DW-1:0]   ram_q;
  logic [RA_W-1:0] ra_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ra_q <= '0;
    else        ra_q <= rd_addr;
  end

  always_ff @(posedge clk) begin
    if (we) ram[wa] <= wd;
    ram_q <= ram[rd_addr[AW-1:0]];
  end

  assign rd_data = ra_q[AW] ? ram_q : PROG[int'(ra_q[AW-1:0]) * DW +: DW];
endmodule

// File: rtl/acc8_core.sv
module acc8_core import acc8_pkg::*; #(
  parameter logic [DW*ROM_BYTES-1:0] PROG = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] io_in,
  output logic [DW-1:0] io_out,
  output logic [DW-1:0] acc,
  output logic          halted
);
  state_e        state_q, state_d;
  logic [AW-1:0] pc_q, pc_d, ptr_q, ptr_d;
  logic [DW-1:0] acc_q, acc_d, ir_q, ir_d, out_q, out_d;
  logic          c_q, c_d;

  logic [RA_W-1:0] rd_addr;
  logic            mem_we;
  logic [AW-1:0]   mem_wa;
  logic [DW-1:0]   mem_wd;
  logic [DW-1:0]   rd_data;

  logic [AW-1:0] pc_inc;
  logic [2:0]    alu_fn;
  logic [DW-1:0] alu_y, sh_y;
  logic          alu_c, alu_cwe, sh_c;
  logic          br_taken;
  logic [AW-1:0] br_next;

  acc8_mem #(.PROG(PROG)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .we(mem_we),
    .wa(mem_wa), .wd(mem_wd), .rd_data(rd_data)
  );

  assign alu_fn = ir_q[DW-1] ? ir_q[2:0] : ir_q[6:4];

  acc8_alu #(.W(DW)) u_alu (
    .fn(alu_fn), .a(acc_q), .b(rd_data), .cin(c_q),
    .y(alu_y), .cout(alu_c), .cwe(alu_cwe)
  );

  acc8_shift #(.W(DW)) u_shift (
    .fn(ir_q[1:0]), .a(acc_q), .cin(c_q), .y(sh_y), .cout(sh_c)
  );

  function automatic logic [RA_W-1:0] reg_rd(input logic [RIDX-1:0] r);
    return {1'b1, {(AW-RIDX){1'b0}}, r};
  endfunction

  assign pc_inc = pc_q + 1'b1;

  always_comb begin
    case (ir_q[1:0])
      2'b00:   br_taken = 1'b1;
      2'b10:   br_taken = (acc_q == '0);
      2'b11:   br_taken = (acc_q != '0);
      default: br_taken = 1'b0;
    endcase
    br_next = br_taken ? rd_data : pc_inc;
  end

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    acc_d   = acc_q;
    c_d     = c_q;
    ir_d    = ir_q;
    out_d   = out_q;
    ptr_d   = ptr_q;
    rd_addr = {1'b0, pc_q};
    mem_we  = 1'b0;
    mem_wa  = {{(AW-RIDX){1'b0}}, ir_q[RIDX-1:0]};
    mem_wd  = acc_q;
    case (state_q)
      S_FETCH: begin
        ir_d = rd_data;
        if (rd_data == EXIT_CODE) begin
          state_d = S_EXIT;
        end else begin
          pc_d    = pc_inc;
          state_d = S_EXEC;
          if (!rd_data[DW-1] || rd_data[7:4] == OP_STI)
            rd_addr = reg_rd(rd_data[RIDX-1:0]);
          else
            rd_addr = {1'b0, pc_inc};
        end
      end
      S_EXEC: begin
        state_d = S_FETCH;
        if (!ir_q[DW-1]) begin
          acc_d = alu_y;
          if (alu_cwe) c_d = alu_c;
        end else begin
          case (ir_q[7:4])
            OP_ST: mem_we = 1'b1;
            OP_BRL: begin
              mem_we  = 1'b1;
              mem_wd  = pc_q;
              pc_d    = acc_q;
              rd_addr = {1'b0, acc_q};
            end
            OP_LDI: begin
              rd_addr = reg_rd(ir_q[RIDX-1:0]);
              state_d = S_LDI1;
            end
            OP_STI: begin
              ptr_d   = rd_data;
              state_d = S_STI;
            end
            OP_ALUI: begin
              acc_d   = alu_y;
              if (alu_cwe) c_d = alu_c;
              pc_d    = pc_inc;
              rd_addr = {1'b0, pc_inc};
            end
            OP_BR: begin
              pc_d    = br_next;
              rd_addr = {1'b0, br_next};
            end
            OP_SH: begin
              acc_d = sh_y;
              c_d   = sh_c;
            end
            OP_IO: begin
              out_d = acc_q;
              acc_d = io_in;
            end
            default: state_d = S_FETCH;
          endcase
        end
      end
      S_LDI1: begin
        rd_addr = {1'b1, rd_data};
        state_d = S_LDI2;
      end
      S_LDI2: begin
        acc_d   = rd_data;
        state_d = S_FETCH;
      end
      S_STI: begin
        mem_we  = 1'b1;
        mem_wa  = ptr_q;
        state_d = S_FETCH;
      end
      S_EXIT:  state_d = S_EXIT;
      default: state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      acc_q   <= '0;
      c_q     <= 1'b0;
      ir_q    <= '0;
      out_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      acc_q   <= acc_d;
      c_q     <= c_d;
      ir_q    <= ir_d;
      out_q   <= out_d;
      ptr_q   <= ptr_d;
    end
  end

  assign io_out = out_q;
  assign acc    = acc_q;
  assign halted = (state_q == S_EXIT);
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk import acc8_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input state_e        state,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] io_out,
  input logic          halted,
  input logic [DW-1:0] ir,
  input logic          mem_we
);
  // R12: once parked, nothing architectural moves
  a_r12_exit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(acc) && $stable(io_out) && $stable(pc)));

  // R7: the pointer read is always followed by the data stage
  a_r7_ldind_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LDI1) |=> (state == S_LDI2));

  // R8: the indirect write stage lasts one cycle and returns to fetch
  a_r8_stind_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STI) |=> (state == S_FETCH));

  // R5: RAM writes only from execute or the indirect write stage
  a_r5_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == S_EXEC || state == S_STI));

  // R2: the accumulator is quiet in fetch and in the middle stages
  a_r2_acc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH || state == S_LDI1 || state == S_STI) |=> $stable(acc));

  // R11: only an executing I/O instruction touches the output byte
  a_r11_out_only_io: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == S_EXEC && ir[7:4] == OP_IO) |=> $stable(io_out));

  // R7: program counter holds through the indirect stages
  a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LDI1 || state == S_LDI2 || state == S_STI) |=> $stable(pc));
endmodule

bind acc8_core acc8_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .pc(pc_q), .acc(acc),
  .io_out(io_out), .halted(halted), .ir(ir_q), .mem_we(mem_we)
);

// File: tb/acc8_core_tb_top.sv
`timescale 1ns/1ps
module acc8_core_tb_top;
  localparam int LIMIT = 5000;

  localparam logic [7:0] IMG [64] = '{
    8'hC7, 8'h12, 8'h81, 8'hC7, 8'h34, 8'h82, 8'h71, 8'h02,
    8'hC7, 8'hF0, 8'hC0, 8'h20, 8'hC2, 8'h01, 8'hC1, 8'h13,
    8'hC3, 8'h00, 8'hC4, 8'h0F, 8'hC5, 8'h30, 8'hC6, 8'hFF,
    8'hE2, 8'hE3, 8'hE1, 8'hE0, 8'h83, 8'hC7, 8'h50, 8'h84,
    8'hB4, 8'hC7, 8'h00, 8'hA4, 8'h13, 8'h73, 8'h13, 8'hD2,
    8'h2B, 8'hC7, 8'hEE, 8'hD1, 8'h29, 8'hD3, 8'h29, 8'hC7,
    8'h3A, 8'hD3, 8'h35, 8'hC7, 8'hEE, 8'h95, 8'hF1, 8'h76,
    8'hF2, 8'hFF, 8'hD0, 8'h3E, 8'hC7, 8'hEE, 8'h75, 8'h96
  };

  function automatic logic [2047:0] mk_prog();
    logic [2047:0] p;
    p = '1;
    for (int i = 0; i < 64; i++) p[i*8 +: 8] = IMG[i];
    return p;
  endfunction

  localparam logic [2047:0] PROG = mk_prog();

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out, acc;
  logic       halted;

  acc8_core #(.PROG(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_in(io_in),
    .io_out(io_out), .acc(acc), .halted(halted)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int    m_acc, m_c, m_pc, m_out, m_left;
  bit    m_halt;
  string m_tag = "R1";
  int    dmem [256];

  function automatic int rom_at(input int a);
    return int'(PROG[(a & 255)*8 +: 8]);
  endfunction

  function automatic int cycles_of(input int op);
    if (op == 255) return 1;
    if ((op >> 4) == 10) return 4;
    if ((op >> 4) == 11) return 3;
    return 2;
  endfunction

  task automatic alu_op(input int f, input int b);
    int t;
    case (f)
      0: begin t = m_acc + b;                m_c = (t > 255) ? 1 : 0; m_acc = t & 255; end
      1: begin t = m_acc - b;                m_c = (t >= 0) ? 1 : 0; m_acc = t & 255; end
      2: begin t = m_acc + b + m_c;          m_c = (t > 255) ? 1 : 0; m_acc = t & 255; end
      3: begin t = m_acc - b - (1 - m_c);    m_c = (t >= 0) ? 1 : 0; m_acc = t & 255; end
      4: m_acc = m_acc & b;
      5: m_acc = m_acc | b;
      6: m_acc = m_acc ^ b;
      default: m_acc = b;
    endcase
  endtask

  task automatic retire();
    int op, r, t;
    op = rom_at(m_pc);
    r  = op & 15;
    if (op == 255) begin
      m_halt = 1; m_tag = "R12";
    end else if (op < 128) begin
      alu_op((op >> 4) & 7, dmem[r]);
      m_pc = (m_pc + 1) & 255;
      m_tag = (((op >> 4) & 7) < 4) ? "R4" : "R2";
    end else begin
      case (op >> 4)
        8:  begin dmem[r] = m_acc; m_pc = (m_pc + 1) & 255; m_tag = "R5"; end
        9:  begin dmem[r] = (m_pc + 1) & 255; m_pc = m_acc; m_tag = "R6"; end
        10: begin m_acc = dmem[dmem[r]]; m_pc = (m_pc + 1) & 255; m_tag = "R7"; end
        11: begin dmem[dmem[r]] = m_acc; m_pc = (m_pc + 1) & 255; m_tag = "R8"; end
        12: begin alu_op(op & 7, rom_at(m_pc + 1)); m_pc = (m_pc + 2) & 255; m_tag = "R3"; end
        13: begin
          case (op & 3)
            0: t = 1;
            2: t = (m_acc == 0) ? 1 : 0;
            3: t = (m_acc != 0) ? 1 : 0;
            default: t = 0;
          endcase
          m_pc = t ? rom_at(m_pc + 1) : ((m_pc + 2) & 255);
          m_tag = "R9";
        end
        14: begin
          case (op & 3)
            0: begin m_c = (m_acc >> 7) & 1; m_acc = (m_acc << 1) & 255; end
            1: begin m_c = m_acc & 1; m_acc = m_acc >> 1; end
            2: begin t = (m_acc >> 7) & 1; m_acc = ((m_acc << 1) | m_c) & 255; m_c = t; end
            default: begin t = m_acc & 1; m_acc = (m_acc >> 1) | (m_c << 7); m_c = t; end
          endcase
          m_pc = (m_pc + 1) & 255; m_tag = "R10";
        end
        default: begin m_out = m_acc; m_acc = int'(io_in); m_pc = (m_pc + 1) & 255; m_tag = "R11"; end
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_c = 0; m_pc = 0; m_out = 0; m_halt = 0;
      m_left = cycles_of(rom_at(0)); m_tag = "R1";
    end else if (!m_halt) begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        retire();
        if (!m_halt) m_left = cycles_of(rom_at(m_pc));
      end
    end
  end

  // per-cycle comparison, away from the active edge
  logic [7:0] last_out = 8'h00;
  logic [7:0] outs [$];
  bit         run = 1'b0;

  always @(negedge clk) begin
    cyc++;
    io_in <= 8'(cyc * 37 + 5);
    if (run) begin
      chk(acc == 8'(m_acc), m_tag, "acc", int'(acc), m_acc);
      chk(io_out == 8'(m_out), m_tag, "io_out", int'(io_out), m_out);
      chk(halted == m_halt, m_tag, "halted", int'(halted), int'(m_halt));
      if (io_out != last_out) begin
        outs.push_back(io_out);
        last_out = io_out;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(acc == 8'h00, "R1", "acc in reset", int'(acc), 0);
    chk(io_out == 8'h00, "R1", "io_out in reset", int'(io_out), 0);
    chk(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
    rst_n = 1'b1;
    #1;
    chk(acc == 8'h00, "R1", "acc after release", int'(acc), 0);
    chk(halted == 1'b0, "R1", "halted after release", int'(halted), 0);
    run = 1'b1;
    while (!m_halt && cyc < LIMIT) @(negedge clk);
    if (!m_halt) begin
      fails++;
      $display("FAIL watchdog: model never reached exit act=%0d exp=halt", cyc);
    end
    // R12: io_in keeps changing after halt; the per-cycle compare watches acc/io_out
    repeat (25) @(negedge clk);
    #1;
    chk(halted == 1'b1, "R12", "halted held", int'(halted), 1);
    chk(outs.size() == 2, "R11", "output updates", outs.size(), 2);
    if (outs.size() == 2) begin
      chk(outs[0] == 8'h36, "R6", "first link seen on io_out", int'(outs[0]), 'h36);
      chk(outs[1] == 8'h40, "R6", "return link seen on io_out", int'(outs[1]), 'h40);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule